// File: doc/BRIEF.md
# Paced Framebuffer Write Queue

This block sits between a processor-side write port and the write port of a framebuffer RAM. Pixel writes land in a short first-in-first-out queue of 16-bit word entries. A write is acknowledged after a short fixed access time whenever the queue has room. The queue then commits entries to the RAM at a slower fixed interval. When the queue cannot take a write, the acknowledge is held back and the writer waits with its request raised.

Byte, word and 32-bit writes are accepted. A 32-bit write becomes two consecutive word entries. It is acknowledged only when both entries fit at once, so nothing from another write can come between its two halves. Each write carries a window select. In the overwrite window every data byte equal to zero has its byte-enable cleared before the entry is queued. The RAM then leaves that pixel unchanged, so colour index zero acts as transparent. Every other value, such as 0x10, is written as usual.

The writer holds `wr_req` together with stable size, address, data and window until it sees `wr_ready` high at a rising edge. That edge is the handshake. On the next edge the writer may present a new write or drop the request.

Top module: `fb_write_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, `fb_we` and `wr_ready` are 0 and the queue is empty.
- R2: With room in the queue, a write whose request is held is acknowledged in its ACC_LAT-th cycle (default 3). `wr_ready` is never high in the first cycle of a request when ACC_LAT is above 1.
- R3: The queue holds DEPTH word entries (default 4). When a write does not fit, `wr_ready` stays low until enough entries have drained. No accepted write is lost.
- R4: Two `fb_we` pulses are always at least DRAIN_INT cycles apart (default 5). An entry pushed into an empty queue that has been idle for at least DRAIN_INT cycles appears on `fb_we` in the cycle right after its handshake.
- R5: Under a sustained stream of back-to-back word writes, commits follow one another every DRAIN_INT cycles exactly.
- R6: Entries reach the RAM port in the order they were accepted.
- R7: A word write (`wr_size`=01, 11 treated alike) commits word address `wr_addr>>1` with data `wr_data[15:0]` and byte-enables 2'b11.
- R8: A byte write (`wr_size`=00) commits `wr_data[7:0]` on both byte lanes. At an even byte address it enables the upper lane only (`fb_be`=2'b10, data in `fb_data[15:8]`). At an odd address it enables the lower lane only (2'b01, `fb_data[7:0]`).
- R9: A 32-bit write (`wr_size`=10) is accepted only when two entries are free. It commits word address `{wr_addr[19:2],0}` with `wr_data[31:16]`, and then, as the very next commit, word address `{wr_addr[19:2],1}` with `wr_data[15:0]`.
- R10: With `wr_ovl`=1, each byte-enable whose data byte is 0x00 is cleared (bit 1 for `fb_data[15:8]`, bit 0 for `fb_data[7:0]`). Nonzero bytes, 0x10 included, keep their enable. An entry with both enables cleared still takes a slot and a commit with `fb_be`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, held until acknowledged |
| wr_size | input | 2 | 00 byte, 01 word, 10 32-bit, 11 word |
| wr_addr | input | 20 | Byte address of the write |
| wr_data | input | 32 | Write data; bytes and words use the low bits |
| wr_ovl | input | 1 | 1 selects the overwrite window |
| wr_ready | output | 1 | Acknowledge; handshake at the edge where it is high |
| fb_we | output | 1 | Commit strobe for one word this cycle |
| fb_addr | output | 19 | Word address of the commit |
| fb_data | output | 16 | Word data of the commit |
| fb_be | output | 2 | Byte-enables, bit 1 upper lane, bit 0 lower lane |

## Verification
Accepting a write and committing the head entry can fall on the same rising edge, and so can a 32-bit double push together with a commit. A stream of a dozen back-to-back word writes, and then a 32-bit write pushed while the queue is nearly full, makes these collisions occur many times. A scoreboard fed by the driver takes each commit off an expected queue and compares address, data and enables. A commit that is lost, duplicated or reordered therefore shows up as a mismatch or as a leftover item. The commit spacing is timed at the same point, and the stall is judged from the measured acknowledge latency.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
    localparam int FBW_AW    = 19;   // word address width
    localparam int FBW_WW    = 16;   // queue entry data width
    localparam int FBW_LANES = FBW_WW / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_WALT = 2'b11
    } fbw_size_e;

    typedef struct packed {
        logic [FBW_AW-1:0]    addr;
        logic [FBW_WW-1:0]    data;
        logic [FBW_LANES-1:0] be;
    } fbw_entry_t;
endpackage

// File: rtl/fbw_entry_gen.sv
module fbw_entry_gen
    import fbw_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [FBW_AW:0]   addr,
    input  logic [31:0]       data,
    input  logic              ovl,
    output fbw_entry_t        ent_first,
    output fbw_entry_t        ent_second,
    output logic              is_long
);
    logic [FBW_AW-1:0]    raw_addr [2];
    logic [FBW_WW-1:0]    raw_data [2];
    logic [FBW_LANES-1:0] raw_be   [2];
    logic [FBW_LANES-1:0] kept_be  [2];

    always_comb begin
        is_long     = (fbw_size_e'(size) == SZ_LONG);
        raw_addr[0] = addr[FBW_AW:1];
        raw_addr[1] = addr[FBW_AW:1];
        raw_data[0] = data[FBW_WW-1:0];
        raw_data[1] = data[FBW_WW-1:0];
        raw_be[0]   = '1;
        raw_be[1]   = '1;
        unique case (fbw_size_e'(size))
            SZ_BYTE: begin
                raw_data[0] = {data[7:0], data[7:0]};
                raw_be[0]   = addr[0] ? 2'b01 : 2'b10;
            end
            SZ_LONG: begin
                raw_addr[0] = {addr[FBW_AW:2], 1'b0};
                raw_addr[1] = {addr[FBW_AW:2], 1'b1};
                raw_data[0] = data[31:16];
                raw_data[1] = data[15:0];
            end
            default: ;
        endcase
    end

    // transparent-zero masking, one instance per half and per byte lane
    for (genvar h = 0; h < 2; h++) begin : g_half
        for (genvar l = 0; l < FBW_LANES; l++) begin : g_lane
            assign kept_be[h][l] = raw_be[h][l] & ~(ovl && (raw_data[h][8*l +: 8] == 8'h00));
        end
    end

    assign ent_first  = '{addr: raw_addr[0], data: raw_data[0], be: kept_be[0]};
    assign ent_second = '{addr: raw_addr[1], data: raw_data[1], be: kept_be[1]};
endmodule

// File: rtl/fbw_pacer.sv
module fbw_pacer #(
    parameter int DRAIN_INT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    output logic fire
);
    localparam int TW = $clog2(DRAIN_INT + 1);
    localparam logic [TW-1:0] TOP = TW'(DRAIN_INT - 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
    } pace_t;

    pace_t st_d, st_q;

    assign fire = nonempty && (st_q.tmr == TOP);

    always_comb begin
        st_d = st_q;
        if (fire)              st_d.tmr = '0;
        else if (st_q.tmr != TOP) st_d.tmr = st_q.tmr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{tmr: TOP};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fbw_queue.sv
module fbw_queue
    import fbw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         push_two,
    input  fbw_entry_t                   ent_first,
    input  fbw_entry_t                   ent_second,
    input  logic                         pop,
    output fbw_entry_t                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        fbw_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CW-1:0]          cnt;
    } q_t;

    q_t st_d, st_q;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop) st_d.rp = adv(st_q.rp);
        if (push) begin
            st_d.mem[st_q.wp] = ent_first;
            st_d.wp           = adv(st_q.wp);
            if (push_two) begin
                st_d.mem[adv(st_q.wp)] = ent_second;
                st_d.wp                = adv(adv(st_q.wp));
            end
        end
        st_d.cnt = st_q.cnt + CW'(push) + CW'(push && push_two) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
endmodule

// File: rtl/fb_write_fifo.sv
module fb_write_fifo
    import fbw_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int ACC_LAT   = 3,
    parameter int DRAIN_INT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_req,
    input  logic [1:0]           wr_size,
    input  logic [FBW_AW:0]      wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 wr_ovl,
    output logic                 wr_ready,
    output logic                 fb_we,
    output logic [FBW_AW-1:0]    fb_addr,
    output logic [FBW_WW-1:0]    fb_data,
    output logic [FBW_LANES-1:0] fb_be
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(ACC_LAT + 1);
    localparam logic [AW-1:0] ACC_TOP = AW'(ACC_LAT - 1);

    typedef struct packed {
        logic [AW-1:0] acc;
    } acc_t;

    acc_t       st_d, st_q;
    fbw_entry_t ent_first, ent_second, head;
    logic       is_long, room, fire;
    logic [CW-1:0] q_cnt;

    fbw_entry_gen u_gen (
        .size       (wr_size),
        .addr       (wr_addr),
        .data       (wr_data),
        .ovl        (wr_ovl),
        .ent_first  (ent_first),
        .ent_second (ent_second),
        .is_long    (is_long)
    );

    // room is judged on the occupancy before this cycle's commit
    assign room     = is_long ? (int'(q_cnt) + 2 <= DEPTH) : (int'(q_cnt) + 1 <= DEPTH);
    assign wr_ready = wr_req && (st_q.acc == ACC_TOP) && room;

    always_comb begin
        st_d = st_q;
        if (!wr_req || wr_ready)   st_d.acc = '0;
        else if (st_q.acc != ACC_TOP) st_d.acc = st_q.acc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fbw_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_ready),
        .push_two   (is_long),
        .ent_first  (ent_first),
        .ent_second (ent_second),
        .pop        (fire),
        .head       (head),
        .count      (q_cnt)
    );

    fbw_pacer #(.DRAIN_INT(DRAIN_INT)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .nonempty (q_cnt != '0),
        .fire     (fire)
    );

    assign fb_we   = fire;
    assign fb_addr = head.addr;
    assign fb_data = head.data;
    assign fb_be   = head.be;
endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
    parameter int DEPTH     = 4,
    parameter int ACC_LAT   = 3,
    parameter int DRAIN_INT = 5,
    parameter int CW        = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic [1:0]    wr_size,
    input logic          wr_ready,
    input logic          fb_we,
    input logic [CW-1:0] q_cnt
);
    localparam int GW = $clog2(DRAIN_INT + 1);
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fb_we) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(DRAIN_INT)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_drain_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_we && seen_q) |-> (int'(gap_q) >= DRAIN_INT - 1));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_cnt) <= DEPTH);

    assert_commit_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> (q_cnt != '0));

    assert_first_cycle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_req) && ACC_LAT > 1) |-> !wr_ready);

    assert_ready_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> wr_req);

    assert_long_two_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_size == 2'b10) |-> (int'(q_cnt) + 2 <= DEPTH));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!fb_we && q_cnt == '0));
endmodule

bind fb_write_fifo fbw_checker #(
    .DEPTH(DEPTH), .ACC_LAT(ACC_LAT), .DRAIN_INT(DRAIN_INT), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_size(wr_size),
    .wr_ready(wr_ready), .fb_we(fb_we), .q_cnt(q_cnt)
);

// File: tb/fb_write_fifo_tb.sv
module fb_write_fifo_tb;
    import fbw_pkg::*;

    localparam int DRAIN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_req = 1'b0;
    logic [1:0] wr_size = 2'b01;
    logic [FBW_AW:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic wr_ovl = 1'b0;
    logic wr_ready, fb_we;
    logic [FBW_AW-1:0] fb_addr;
    logic [15:0] fb_data;
    logic [1:0] fb_be;

    always #2.5 clk = ~clk;

    fb_write_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_size(wr_size),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ovl(wr_ovl),
        .wr_ready(wr_ready), .fb_we(fb_we), .fb_addr(fb_addr),
        .fb_data(fb_data), .fb_be(fb_be)
    );

    typedef struct {
        logic [FBW_AW-1:0] addr;
        logic [15:0] data;
        logic [1:0] be;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_commit = -100;
    int commit_times[$];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] mask_be(input logic [1:0] be, input logic [15:0] d, input logic ovl);
        logic [1:0] r = be;
        if (ovl && d[15:8] == 8'h00) r[1] = 1'b0;
        if (ovl && d[7:0]  == 8'h00) r[0] = 1'b0;
        return r;
    endfunction

    // driver: expectation from the requirements, then handshake
    task automatic do_write(input logic [1:0] sz, input logic [FBW_AW:0] a,
                            input logic [31:0] d, input logic ovl, input string tag,
                            output int lat);
        exp_t e;
        if (sz == 2'b00) begin
            e.addr = a[FBW_AW:1];
            e.data = {d[7:0], d[7:0]};
            e.be   = mask_be(a[0] ? 2'b01 : 2'b10, {d[7:0], d[7:0]}, ovl);
            e.tag  = tag; exp_q.push_back(e);
        end else if (sz == 2'b10) begin
            e.addr = {a[FBW_AW:2], 1'b0}; e.data = d[31:16];
            e.be   = mask_be(2'b11, d[31:16], ovl); e.tag = tag; exp_q.push_back(e);
            e.addr = {a[FBW_AW:2], 1'b1}; e.data = d[15:0];
            e.be   = mask_be(2'b11, d[15:0], ovl); e.tag = tag; exp_q.push_back(e);
        end else begin
            e.addr = a[FBW_AW:1]; e.data = d[15:0];
            e.be   = mask_be(2'b11, d[15:0], ovl); e.tag = tag; exp_q.push_back(e);
        end
        @(negedge clk);
        wr_req = 1'b1; wr_size = sz; wr_addr = a; wr_data = d; wr_ovl = ovl;
        lat = 0;
        forever begin
            #1;
            lat++;
            if (wr_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #0.5 wr_req = 1'b0;
    endtask

    // monitor: pop and compare each commit, time the spacing
    always @(negedge clk) begin
        if (rst_n && fb_we && !done) begin
            exp_t e;
            commit_times.push_back(cyc);
            check(cyc - last_commit >= DRAIN, "R4", "commit spacing", cyc - last_commit, DRAIN);
            last_commit = cyc;
            if (exp_q.size() == 0) begin
                check(0, "R6", "unexpected commit addr", fb_addr, 0);
            end else begin
                e = exp_q.pop_front();
                check(fb_addr == e.addr, e.tag, "fb_addr", fb_addr, e.addr);
                check(fb_data == e.data, e.tag, "fb_data", fb_data, e.data);
                check(fb_be == e.be, e.tag, "fb_be", fb_be, e.be);
            end
        end
    end

    task automatic drain_wait();
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk); n++;
        end
        repeat (DRAIN + 1) @(negedge clk);
        check(exp_q.size() == 0, "R3", "items left undelivered", exp_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, queue items left=%0d expected=0", exp_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        int lat;
        int maxlat;
        repeat (3) @(negedge clk);
        check(fb_we == 1'b0, "R1", "fb_we in reset", fb_we, 0);
        check(wr_ready == 1'b0, "R1", "wr_ready in reset", wr_ready, 0);
        @(negedge clk) rst_n = 1'b1;
        #1 check(fb_we == 1'b0, "R1", "fb_we after reset", fb_we, 0);
        repeat (DRAIN + 2) @(negedge clk);

        // R2/R4/R7: single word into an idle queue
        do_write(2'b01, 20'h01234, 32'hDEAD_BEEF, 1'b0, "R7", lat);
        check(lat == 3, "R2", "accept latency", lat, 3);
        @(negedge clk);
        check(fb_we == 1'b1, "R4", "idle commit next cycle", fb_we, 1);
        drain_wait();

        // R8: byte lanes
        do_write(2'b00, 20'h00100, 32'h0000_00A5, 1'b0, "R8", lat);
        do_write(2'b00, 20'h00101, 32'h0000_005A, 1'b0, "R8", lat);
        // R7: size code 11 behaves as word
        do_write(2'b11, 20'h00202, 32'h0000_1357, 1'b0, "R7", lat);
        drain_wait();

        // R10: transparent zero in the overwrite window
        do_write(2'b01, 20'h00300, 32'h0000_0010, 1'b1, "R10", lat);
        do_write(2'b01, 20'h00302, 32'h0000_1000, 1'b1, "R10", lat);
        do_write(2'b00, 20'h00304, 32'h0000_0000, 1'b1, "R10", lat);
        do_write(2'b00, 20'h00305, 32'h0000_0010, 1'b1, "R10", lat);
        do_write(2'b10, 20'h00308, 32'h00AB_0000, 1'b1, "R10", lat);
        do_write(2'b01, 20'h0030C, 32'h0000_0000, 1'b0, "R10", lat);
        drain_wait();

        // R5/R3/R6: sustained burst, accept collides with commit
        commit_times.delete();
        maxlat = 0;
        for (int i = 0; i < 12; i++) begin
            do_write(2'b01, 20'h04000 + 20'(2 * i), 32'h0000_A000 + 32'(i), 1'b0, "R6", lat);
            if (lat > maxlat) maxlat = lat;
        end
        check(maxlat > 3, "R3", "stall seen when full", maxlat, 4);
        // R9: 32-bit write into a nearly full queue
        do_write(2'b10, 20'h05004, 32'h1122_3344, 1'b0, "R9", lat);
        check(lat > 3, "R9", "long waits for two slots", lat, 4);
        drain_wait();
        check(commit_times.size() == 14, "R5", "commits in burst", commit_times.size(), 14);
        for (int k = 1; k < commit_times.size(); k++)
            check(commit_times[k] - commit_times[k-1] == DRAIN, "R5", "steady spacing",
                  commit_times[k] - commit_times[k-1], DRAIN);

        // R9: isolated 32-bit write
        do_write(2'b10, 20'h07003, 32'hCAFE_F00D, 1'b0, "R9", lat);
        check(lat == 3, "R2", "long accept latency with room", lat, 3);
        drain_wait();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule